// File: doc/BRIEF.md
# Configurable External Bus Interface

This block is the bus master that sits between an internal 16-bit requester and an external memory/peripheral bus. Each internal request is a whole 16-bit word, read or write. The block turns it into one or two external bus cycles. The shape of those cycles depends on three settings:

- A configuration register sets the address width (16 or 20 lines) and the bus format (separate, or address/data multiplexed in one or both chip-select regions).
- A static `byte_mode` pin sets the external data width (8 or 16 bits).

The block also reports which pin groups it currently owns. Released groups go back to port logic outside this block.

Requests enter on a valid/ready handshake. `req_ready` is high only while the block is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. Results leave on a second handshake. `rsp_valid` rises once the last external strobe has ended. `rsp_valid` and `rsp_rdata` then hold steady until `rsp_ready` is seen high. No new request is taken while a response is waiting, so a slow consumer stalls the whole interface.

Top module: `ext_bus_if`

## Requirements
- R1: After reset:
  - the block is idle, with `req_ready` = 1 and `rsp_valid` = 0;
  - all strobes are inactive (`ext_ale` = 0, `ext_rd_n`, `ext_wr_n`, `ext_cs1_n`, `ext_cs2_n` = 1);
  - the format field is 00 (separate bus) and `cfg_narrow_q` = 0 (20-bit addressing).
- R2: When `cfg_narrow_q` = 1, `ext_addr[19:16]` is 0 and `own_addr_top` = 0. When it is 0, all 20 address lines carry the cycle address and `own_addr_top` = 1.
- R3: `own_data_hi` = 1 when `byte_mode` = 0 (16-bit bus) and 0 when `byte_mode` = 1.
  - `ext_dh_oe` is high, with `ext_dh_out` = write data bits 15:8, only during a write on the 16-bit bus.
  - `ext_dh_out` is 0 at all other times.
- R4: A separate-bus cycle runs, one clock per phase:
  - a setup phase: chip select low, both strobes high;
  - a strobe phase: `ext_rd_n` low for a read, `ext_wr_n` low for a write;
  - a further strobe (wait) phase only when `req_wait` was 1 on the request.
  
  During a write, `ext_ad_oe` is high in every phase and `ext_ad_out` carries the write byte.
- R5: A multiplexed cycle runs:
  - an ALE phase: `ext_ale` = 1, and `ext_ad_out` carries the address slice with `ext_ad_oe` = 1;
  - a hold phase: `ext_ale` = 0, address still on `ext_ad_out`;
  - two strobe phases. The wait phase is always inserted, whatever `req_wait` is.
- R6: The multiplexed address slice on `ext_ad_out` depends on data width:
  - on the 8-bit bus it is address bits 7:0;
  - on the 16-bit bus it is address bits 8:1.
- R7: On the 8-bit bus a request becomes two byte cycles, in this order:
  - first at the request address, carrying data bits 7:0;
  - then at address+1, carrying data bits 15:8.
  
  For a read, the byte returned by the first cycle goes to `rsp_rdata[7:0]` and the byte from the second to `rsp_rdata[15:8]`. On the 16-bit bus, a read returns `{ext_dh_in, ext_ad_in}`, sampled in the last strobe clock.
- R8: Address bit 19 chooses the region: 1 selects region 1 (`ext_cs1_n` low during the cycle), 0 selects region 2 (`ext_cs2_n` low). Format codes:
  - 00: separate bus;
  - 01: multiplexed in region 2 only;
  - 10: multiplexed in region 1 only;
  - 11: multiplexed everywhere.
- R9: A configuration write of format 11 while `byte_mode` = 0 leaves the format field unchanged. The address-width bit of the same write still takes effect.
- R10: While format 11 is in force, `ext_addr[15:9]` is 0 and `own_addr_mid` = 0. Otherwise `own_addr_mid` = 1.
- R11: The response handshake behaves as follows:
  - `req_ready` is 0 from acceptance until the response is taken;
  - `rsp_valid` and `rsp_rdata` stay stable while `rsp_ready` is 0;
  - `req_ready` returns the clock after the response is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_mode | input | 1 | 1 = 8-bit external data bus, 0 = 16-bit; change only while idle |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_narrow_addr | input | 1 | Written value: 1 = 16 address lines |
| cfg_fmt | input | 2 | Written bus format code |
| cfg_fmt_q | output | 2 | Format in force |
| cfg_narrow_q | output | 1 | Address width in force |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Byte address of the word |
| req_wdata | input | 16 | Write data |
| req_wait | input | 1 | Insert a wait on a separate-bus cycle |
| rsp_valid | output | 1 | Access finished |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 16 | Read data |
| ext_addr | output | 20 | Address lines |
| ext_ad_out | output | 8 | Low data / multiplexed address output |
| ext_ad_in | input | 8 | Low data input |
| ext_ad_oe | output | 1 | Low data group driven |
| ext_dh_out | output | 8 | High data output |
| ext_dh_in | input | 8 | High data input |
| ext_dh_oe | output | 1 | High data group driven |
| ext_ale | output | 1 | Address latch enable |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_wr_n | output | 1 | Write strobe, active low |
| ext_cs1_n | output | 1 | Region 1 select, active low |
| ext_cs2_n | output | 1 | Region 2 select, active low |
| own_addr_top | output | 1 | Address lines 19:16 owned by the bus |
| own_addr_mid | output | 1 | Address lines 15:9 owned by the bus |
| own_data_hi | output | 1 | High data group owned by the bus |

## Verification
The phase timing, counted from the request's accepting edge, is:

| Result | Due |
|---|---|
| First bus phase on the pins | The clock after acceptance |
| Each further phase | One clock later |
| Second byte cycle (8-bit bus) | Straight after the last strobe clock of the first |
| `rsp_valid` | The clock after the final strobe clock |

Configuration changes and ownership flags take effect the clock after `cfg_we`.

The bench keeps its own behavioural model of the configuration register. From that model and the request it builds the expected pin vector for every phase, and compares it with the pins at each falling edge. It also drives read data that changes per byte cycle, and holds `rsp_ready` low for a chosen number of clocks to check that the response stays steady under back-pressure.

// File: rtl/ebi_pkg.sv
package ebi_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ALE,
    ST_HOLD,
    ST_STROBE,
    ST_WAIT,
    ST_RESP
  } ebi_state_e;

  typedef enum logic [1:0] {
    FMT_SEP     = 2'b00,
    FMT_MUX_CS2 = 2'b01,
    FMT_MUX_CS1 = 2'b10,
    FMT_MUX_ALL = 2'b11
  } bus_fmt_e;

  // Decide whether a cycle in the given region uses the multiplexed format.
  function automatic logic use_mux(bus_fmt_e fmt, logic region1);
    case (fmt)
      FMT_MUX_ALL: return 1'b1;
      FMT_MUX_CS1: return region1;
      FMT_MUX_CS2: return ~region1;
      default:     return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/ebi_cfg.sv
module ebi_cfg
  import ebi_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     byte_mode,
  input  logic     cfg_we,
  input  logic     cfg_narrow_addr,
  input  logic [1:0] cfg_fmt,
  output bus_fmt_e fmt_q,
  output logic     narrow_q,
  output logic     own_addr_top,
  output logic     own_addr_mid,
  output logic     own_data_hi
);

  logic fmt_legal;
  assign fmt_legal = !(cfg_fmt == 2'b11 && !byte_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q    <= FMT_SEP;
      narrow_q <= 1'b0;
    end else if (cfg_we) begin
      narrow_q <= cfg_narrow_addr;
      if (fmt_legal) fmt_q <= bus_fmt_e'(cfg_fmt);
    end
  end

  assign own_addr_top = ~narrow_q;
  assign own_addr_mid = (fmt_q != FMT_MUX_ALL);
  assign own_data_hi  = ~byte_mode;

  p_reject_wide_full_mux_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !byte_mode && cfg_fmt == 2'b11) |=> $stable(fmt_q));

  p_width_taken_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (narrow_q == $past(cfg_narrow_addr)));

endmodule

// File: rtl/ebi_addr_mask.sv
module ebi_addr_mask #(
  parameter int ADDR_W    = 20,
  parameter int NARROW_AW = 16,
  parameter int MUX_KEEP  = 9
) (
  input  logic [ADDR_W-1:0] byte_addr,
  input  logic              narrow,
  input  logic              full_mux,
  output logic [ADDR_W-1:0] pins
);

  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    if (i >= NARROW_AW) begin : g_top
      assign pins[i] = byte_addr[i] & ~narrow;
    end else if (i >= MUX_KEEP) begin : g_mid
      assign pins[i] = byte_addr[i] & ~full_mux;
    end else begin : g_low
      assign pins[i] = byte_addr[i];
    end
  end

endmodule

// File: rtl/ebi_seq.sv
module ebi_seq
  import ebi_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_mode,
  input  bus_fmt_e          fmt,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_wait,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] byte_addr,
  output logic [DATA_W/2-1:0] ad_out,
  input  logic [DATA_W/2-1:0] ad_in,
  output logic              ad_oe,
  output logic [DATA_W/2-1:0] dh_out,
  input  logic [DATA_W/2-1:0] dh_in,
  output logic              dh_oe,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              cs1_n,
  output logic              cs2_n
);

  localparam int BYTE_W = DATA_W / 2;

  ebi_state_e        state_q, state_d;
  logic              beat_q, wr_q, wait_q, mux_q, eight_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              strobe, addr_phase, active, last_strobe, more_beats;
  logic [BYTE_W-1:0] wbyte;

  assign byte_addr   = eight_q ? addr_q + ADDR_W'(beat_q) : addr_q;
  assign strobe      = (state_q == ST_STROBE) || (state_q == ST_WAIT);
  assign addr_phase  = (state_q == ST_ALE) || (state_q == ST_HOLD);
  assign active      = (state_q != ST_IDLE) && (state_q != ST_RESP);
  assign last_strobe = (state_q == ST_WAIT) ||
                       (state_q == ST_STROBE && !(mux_q || wait_q));
  assign more_beats  = eight_q && !beat_q;
  assign wbyte       = (eight_q && beat_q) ? wdata_q[DATA_W-1:BYTE_W] : wdata_q[BYTE_W-1:0];

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (req_valid) state_d = use_mux(fmt, req_addr[ADDR_W-1]) ? ST_ALE : ST_SETUP;
      ST_SETUP:  state_d = ST_STROBE;
      ST_ALE:    state_d = ST_HOLD;
      ST_HOLD:   state_d = ST_STROBE;
      ST_STROBE, ST_WAIT: begin
        if (state_q == ST_STROBE && (mux_q || wait_q)) state_d = ST_WAIT;
        else if (more_beats) state_d = mux_q ? ST_ALE : ST_SETUP;
        else state_d = ST_RESP;
      end
      ST_RESP:   if (rsp_ready) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= 1'b0;
      wr_q    <= 1'b0;
      wait_q  <= 1'b0;
      mux_q   <= 1'b0;
      eight_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && req_valid) begin
        beat_q  <= 1'b0;
        wr_q    <= req_write;
        wait_q  <= req_wait;
        mux_q   <= use_mux(fmt, req_addr[ADDR_W-1]);
        eight_q <= byte_mode;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (last_strobe) begin
        if (!eight_q) rdata_q <= {dh_in, ad_in};
        else if (!beat_q) rdata_q[BYTE_W-1:0] <= ad_in;
        else rdata_q[DATA_W-1:BYTE_W] <= ad_in;
        if (more_beats) beat_q <= 1'b1;
      end
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_rdata = rdata_q;
  assign ale       = (state_q == ST_ALE);
  assign rd_n      = ~(strobe && !wr_q);
  assign wr_n      = ~(strobe && wr_q);
  assign cs1_n     = ~(active && addr_q[ADDR_W-1]);
  assign cs2_n     = ~(active && !addr_q[ADDR_W-1]);
  assign ad_oe     = active && (addr_phase || wr_q);
  assign ad_out    = !active ? '0 :
                     addr_phase ? (eight_q ? byte_addr[BYTE_W-1:0] : byte_addr[BYTE_W:1]) :
                     (wr_q ? wbyte : '0);
  assign dh_oe     = active && wr_q && !eight_q;
  assign dh_out    = dh_oe ? wdata_q[DATA_W-1:BYTE_W] : '0;

  p_strobes_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  p_select_before_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rd_n) || $fell(wr_n)) |-> $past(!(cs1_n && cs2_n)));

  p_ale_then_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> (!ale && rd_n && wr_n && ad_oe));

  p_mux_forced_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_q && ($fell(rd_n) || $fell(wr_n))) |=> !(rd_n && wr_n));

  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  p_busy_not_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || !(cs1_n && cs2_n)) |-> !req_ready);

endmodule

// File: rtl/ext_bus_if.sv
module ext_bus_if
  import ebi_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 16,
  parameter int NARROW_AW = 16,
  parameter int MUX_KEEP  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_mode,
  input  logic              cfg_we,
  input  logic              cfg_narrow_addr,
  input  logic [1:0]        cfg_fmt,
  output logic [1:0]        cfg_fmt_q,
  output logic              cfg_narrow_q,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_wait,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [DATA_W/2-1:0] ext_ad_out,
  input  logic [DATA_W/2-1:0] ext_ad_in,
  output logic              ext_ad_oe,
  output logic [DATA_W/2-1:0] ext_dh_out,
  input  logic [DATA_W/2-1:0] ext_dh_in,
  output logic              ext_dh_oe,
  output logic              ext_ale,
  output logic              ext_rd_n,
  output logic              ext_wr_n,
  output logic              ext_cs1_n,
  output logic              ext_cs2_n,
  output logic              own_addr_top,
  output logic              own_addr_mid,
  output logic              own_data_hi
);

  bus_fmt_e          fmt;
  logic [ADDR_W-1:0] byte_addr;

  ebi_cfg u_cfg (
    .clk             (clk),
    .rst_n           (rst_n),
    .byte_mode       (byte_mode),
    .cfg_we          (cfg_we),
    .cfg_narrow_addr (cfg_narrow_addr),
    .cfg_fmt         (cfg_fmt),
    .fmt_q           (fmt),
    .narrow_q        (cfg_narrow_q),
    .own_addr_top    (own_addr_top),
    .own_addr_mid    (own_addr_mid),
    .own_data_hi     (own_data_hi)
  );

  assign cfg_fmt_q = fmt;

  ebi_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_mode (byte_mode),
    .fmt       (fmt),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_wait  (req_wait),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata),
    .byte_addr (byte_addr),
    .ad_out    (ext_ad_out),
    .ad_in     (ext_ad_in),
    .ad_oe     (ext_ad_oe),
    .dh_out    (ext_dh_out),
    .dh_in     (ext_dh_in),
    .dh_oe     (ext_dh_oe),
    .ale       (ext_ale),
    .rd_n      (ext_rd_n),
    .wr_n      (ext_wr_n),
    .cs1_n     (ext_cs1_n),
    .cs2_n     (ext_cs2_n)
  );

  ebi_addr_mask #(.ADDR_W(ADDR_W), .NARROW_AW(NARROW_AW), .MUX_KEEP(MUX_KEEP)) u_mask (
    .byte_addr (byte_addr),
    .narrow    (cfg_narrow_q),
    .full_mux  (fmt == FMT_MUX_ALL),
    .pins      (ext_addr)
  );

  p_top_released_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !own_addr_top |-> (ext_addr[ADDR_W-1:NARROW_AW] == '0));

  p_mid_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !own_addr_mid |-> (ext_addr[NARROW_AW-1:MUX_KEEP] == '0));

  p_high_group_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !own_data_hi |-> !ext_dh_oe);

endmodule

// File: tb/ext_bus_if_bench.sv
`timescale 1ns/1ps
module ext_bus_if_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byte_mode = 1'b0;
  logic cfg_we = 1'b0, cfg_narrow_addr = 1'b0;
  logic [1:0] cfg_fmt = 2'b00;
  logic [1:0] cfg_fmt_q;
  logic cfg_narrow_q;
  logic req_valid = 1'b0, req_ready, req_write = 1'b0, req_wait = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic rsp_valid, rsp_ready = 1'b0;
  logic [15:0] rsp_rdata;
  logic [19:0] ext_addr;
  logic [7:0] ext_ad_out, ext_dh_out;
  logic [7:0] ext_ad_in = '0, ext_dh_in = '0;
  logic ext_ad_oe, ext_dh_oe, ext_ale, ext_rd_n, ext_wr_n, ext_cs1_n, ext_cs2_n;
  logic own_addr_top, own_addr_mid, own_data_hi;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;
  bit m_narrow = 1'b0;
  logic [1:0] m_fmt = 2'b00;

  always #2.5 clk = ~clk;

  ext_bus_if u_ext_bus_if (.*);

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [42:0] pins_now();
    return {ext_ale, ext_rd_n, ext_wr_n, ext_cs1_n, ext_cs2_n, ext_ad_oe, ext_dh_oe,
            ext_addr, ext_ad_out, ext_dh_out};
  endfunction

  task automatic write_cfg(input bit narrow, input logic [1:0] fmt, input string tag);
    cfg_we = 1'b1; cfg_narrow_addr = narrow; cfg_fmt = fmt;
    m_narrow = narrow;
    if (!(fmt == 2'b11 && !byte_mode)) m_fmt = fmt;
    @(negedge clk);
    cfg_we = 1'b0;
    check({cfg_fmt_q, cfg_narrow_q} == {m_fmt, m_narrow}, tag, {cfg_fmt_q, cfg_narrow_q}, {m_fmt, m_narrow});
    check({own_addr_top, own_addr_mid, own_data_hi} == {!m_narrow, m_fmt != 2'b11, !byte_mode}, tag,
          {own_addr_top, own_addr_mid, own_data_hi}, {!m_narrow, m_fmt != 2'b11, !byte_mode});
  endtask

  // One whole access; expected pins built per phase from the requirement rules.
  task automatic access(input bit wr, input logic [19:0] a, input logic [15:0] wd, input bit wt,
                        input logic [15:0] rv, input int stall, input string tag);
    bit eight, mux, reg1;
    int beats, nph;
    logic [19:0] baddr, amask;
    logic [42:0] exp;
    logic [7:0] e_ad, e_dh;
    bit e_ale, strb, aph, e_adoe, e_dhoe;
    eight = byte_mode;
    reg1 = a[19];
    mux = (m_fmt == 2'b11) || (m_fmt == 2'b10 && reg1) || (m_fmt == 2'b01 && !reg1);
    beats = eight ? 2 : 1;
    check(req_ready == 1'b1, "R11", req_ready, 1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; req_wait = wt;
    @(negedge clk);
    req_valid = 1'b0;
    for (int b = 0; b < beats; b++) begin
      baddr = eight ? a + 20'(b) : a;
      nph = mux ? 4 : (wt ? 3 : 2);
      for (int p = 0; p < nph; p++) begin
        e_ale = mux && p == 0;
        aph   = mux && p < 2;
        strb  = mux ? (p >= 2) : (p >= 1);
        amask = baddr;
        if (m_narrow) amask[19:16] = 4'h0;
        if (m_fmt == 2'b11) amask[15:9] = 7'h0;
        e_adoe = aph || wr;
        e_ad = aph ? (eight ? baddr[7:0] : baddr[8:1]) :
               (wr ? ((eight && b == 1) ? wd[15:8] : wd[7:0]) : 8'h00);
        e_dhoe = wr && !eight;
        e_dh = e_dhoe ? wd[15:8] : 8'h00;
        exp = {e_ale, !(strb && !wr), !(strb && wr), !reg1, reg1, e_adoe, e_dhoe, amask, e_ad, e_dh};
        ext_ad_in = (eight && b == 1) ? rv[15:8] : rv[7:0];
        ext_dh_in = rv[15:8];
        check(pins_now() == exp, tag, pins_now(), exp);
        check(req_ready == 1'b0 && rsp_valid == 1'b0, "R11", {req_ready, rsp_valid}, 0);
        @(negedge clk);
      end
    end
    for (int s = 0; s < stall; s++) begin
      check(rsp_valid && !req_ready, "R11", {rsp_valid, req_ready}, 2'b10);
      if (!wr) check(rsp_rdata == rv, "R11", rsp_rdata, rv);
      @(negedge clk);
    end
    check(rsp_valid == 1'b1, "R11", rsp_valid, 1);
    if (!wr) check(rsp_rdata == rv, eight ? "R7" : tag, rsp_rdata, rv);
    check({ext_rd_n, ext_wr_n, ext_cs1_n, ext_cs2_n} == 4'hF, "R4", {ext_rd_n, ext_wr_n, ext_cs1_n, ext_cs2_n}, 4'hF);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check(rsp_valid == 1'b0 && req_ready == 1'b1, "R11", {rsp_valid, req_ready}, 2'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({req_ready, rsp_valid, ext_ale, ext_rd_n, ext_wr_n, ext_cs1_n, ext_cs2_n} == 7'b1001111, "R1",
          {req_ready, rsp_valid, ext_ale, ext_rd_n, ext_wr_n, ext_cs1_n, ext_cs2_n}, 7'b1001111);
    check({cfg_fmt_q, cfg_narrow_q} == 3'b000, "R1", {cfg_fmt_q, cfg_narrow_q}, 0);
    check(own_data_hi == 1'b1 && own_addr_top == 1'b1, "R3", {own_data_hi, own_addr_top}, 2'b11);
    // separate 16-bit bus
    access(1'b1, 20'h01234, 16'hBEEF, 1'b0, 16'h0, 0, "R4");
    access(1'b0, 20'h81230, 16'h0, 1'b1, 16'hA55A, 2, "R4");
    access(1'b1, 20'h40000, 16'h1357, 1'b1, 16'h0, 1, "R3");
    // 8-bit bus, split cycles
    byte_mode = 1'b1;
    @(negedge clk);
    check(own_data_hi == 1'b0, "R3", own_data_hi, 0);
    access(1'b0, 20'h80010, 16'h0, 1'b0, 16'hC3D4, 0, "R7");
    access(1'b1, 20'h00FFF, 16'h9A78, 1'b1, 16'h0, 0, "R7");
    // narrow addressing
    write_cfg(1'b1, 2'b00, "R2");
    access(1'b0, 20'hABCDE, 16'h0, 1'b0, 16'h1122, 0, "R2");
    // region 1 multiplexed, region 2 separate
    write_cfg(1'b0, 2'b10, "R8");
    access(1'b0, 20'h80055, 16'h0, 1'b0, 16'h6677, 1, "R5");
    access(1'b1, 20'h00200, 16'h4455, 1'b0, 16'h0, 0, "R8");
    write_cfg(1'b0, 2'b01, "R8");
    access(1'b1, 20'h00281, 16'hE1F2, 1'b0, 16'h0, 0, "R6");
    access(1'b0, 20'hF0000, 16'h0, 1'b0, 16'h3344, 0, "R8");
    // whole space multiplexed on the 8-bit bus
    write_cfg(1'b0, 2'b11, "R10");
    access(1'b1, 20'h0FF44, 16'h0F0F, 1'b0, 16'h0, 0, "R10");
    access(1'b0, 20'hFFE02, 16'h0, 1'b1, 16'h8899, 0, "R10");
    // 16-bit multiplexed: address bits 8:1 on the low group
    write_cfg(1'b0, 2'b01, "R8");
    byte_mode = 1'b0;
    @(negedge clk);
    access(1'b0, 20'h00346, 16'h0, 1'b0, 16'h5AA5, 0, "R6");
    access(1'b1, 20'h001FE, 16'hCAFE, 1'b0, 16'h0, 0, "R6");
    // full multiplexing refused on the wide bus, width bit still taken
    write_cfg(1'b1, 2'b11, "R9");
    check(cfg_fmt_q == 2'b01, "R9", cfg_fmt_q, 2'b01);
    access(1'b0, 20'h7F346, 16'h0, 1'b0, 16'h2468, 0, "R9");
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule